// File: doc/BRIEF.md
# Word FIFO to Card Byte Stream Engine

This block sits between a 32-bit host data port and a byte-wide card data port. It holds a 16-word circular FIFO. In the read direction it gathers bytes arriving from the card into words, least significant byte first, and pushes them into the FIFO. In the write direction it pulls words that the host has pushed and sends their bytes to the card, least significant byte first. The host pops words from the FIFO in the read direction and pushes them in the write direction.

A transfer starts when a load strobe sets the remaining byte count to the block count times the block size. The counter drops by one for each byte moved, and at most one byte moves per clock. When the count runs out, the block raises a sticky completion status bit and switches its state field to data mode. It can also raise three sticky interrupt bits, each gated by a configuration enable and, for two of them, by the command type. The block also reports its FIFO fill level.

Top module: `sbe_byte_engine`

## Requirements
- R1: The FIFO holds 16 words. `dbg_fill` shows its occupancy (0 to 16). A host push while the FIFO is full is dropped and leaves the contents unchanged.
- R2: In the read direction (`cmd_rd`=1), `host_rdata` shows the oldest word, or 0 when the FIFO is empty. A `data_rd` strobe removes that word. A strobe on an empty FIFO changes nothing.
- R3: A `cnt_load` strobe sets the remaining count to `blk_cnt` × `blk_size` and discards any partly packed or partly sent word.
- R4: `card_rd_ready` is high only when `cmd_rd`=1, the remaining count is nonzero and the FIFO is not full. A byte is taken on a cycle where both `card_rd_valid` and `card_rd_ready` are high.
- R5: Read packing is little-endian. The first byte of a word goes to bits 7:0, the second to 15:8, the third to 23:16 and the fourth to 31:24. The word is pushed when its fourth byte arrives.
- R6: When the last byte of a transfer completes only part of a word, that word is pushed anyway, with its unfilled upper bytes at zero.
- R7: In the write direction (`cmd_rd`=0), `card_wr_valid` is high while bytes remain and either a word is being sent or the FIFO is not empty. Bytes go out least significant first, one per `card_wr_valid`/`card_wr_ready` handshake. Bytes of the current word that are left when the count reaches zero are dropped. `card_wr_valid` stays low in the read direction.
- R8: Completion sets `status` bit 0 and sets `dbg_state` to 1 (data mode). The reset value of `dbg_state` is 0.
- R9: Completion also sets `status` bit 8 when `cfg_data_ie` is 1.
- R10: Completion sets `status` bit 10 when both `cmd_busywait` and `cfg_busy_ie` are 1. It sets bit 9 when both `cmd_wr` and `cfg_block_ie` are 1. `irq` is the OR of status bits 10:8.
- R11: Completion happens when the last byte moves, on a `cnt_load` whose product is zero, and on any `kick`, `data_wr` or `data_rd` cycle in which the count is already zero.
- R12: On a `sts_clr_we` cycle, status bits set in `sts_clr_mask` clear. A completion in the same cycle wins. Status bits other than 0, 8, 9 and 10 always read 0.
- R13: `data_wr` pushes nothing in the read direction, and `data_rd` pops nothing in the write direction.
- R14: Synchronous active-low reset empties the FIFO, clears the count, the packing and sending state and the status, and sets `dbg_state` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_rd | input | 1 | Transfer direction: 1 = card to host |
| cmd_wr | input | 1 | Current command is a write |
| cmd_busywait | input | 1 | Current command waits for busy |
| cfg_data_ie | input | 1 | Enables status bit 8 |
| cfg_block_ie | input | 1 | Enables status bit 9 |
| cfg_busy_ie | input | 1 | Enables status bit 10 |
| kick | input | 1 | Command issue or configuration write strobe (re-evaluates completion) |
| cnt_load | input | 1 | Loads the remaining byte count |
| blk_cnt | input | 9 | Block count |
| blk_size | input | 16 | Bytes per block |
| data_wr | input | 1 | Host push strobe |
| data_wdata | input | 32 | Host push word |
| data_rd | input | 1 | Host pop strobe |
| host_rdata | output | 32 | Oldest FIFO word, 0 when empty |
| card_rd_valid | input | 1 | Card byte available |
| card_rd_data | input | 8 | Card byte |
| card_rd_ready | output | 1 | Engine accepts a card byte |
| card_wr_valid | output | 1 | Engine offers a byte to the card |
| card_wr_data | output | 8 | Byte to the card |
| card_wr_ready | input | 1 | Card accepts the byte |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 11 | Status bits to clear |
| status | output | 11 | Sticky status bits 0, 8, 9, 10 |
| irq | output | 1 | OR of status bits 10:8 |
| dbg_state | output | 4 | Engine state field |
| dbg_fill | output | 5 | FIFO occupancy |

## Verification
The assertions assume that `cmd_rd`, `cmd_wr` and the configuration enables change only while no byte is moving. They also assume that `cnt_load` never coincides with a byte handshake, since the load wins and that byte's bookkeeping would be lost. The stimulus meets both conditions: it sets the direction and the enables first, and it loads the count only while the card port is idle or the count is zero. The card source and sink then toggle valid and ready in irregular patterns, and a behavioural model tracks the FIFO as a queue.

// File: rtl/sbe_pkg.sv
// Shared constants and types for the word FIFO / byte stream engine.
// Assumes an 11-bit status word with four implemented bits.
package sbe_pkg;
    localparam int STS_W        = 11;
    localparam int ST_DONE      = 0;
    localparam int ST_DATA_IRQ  = 8;
    localparam int ST_BLOCK_IRQ = 9;
    localparam int ST_BUSY_IRQ  = 10;
    localparam logic [STS_W-1:0] STS_IMPL = 11'h701;

    typedef enum logic [3:0] {
        MODE_IDENT = 4'd0,
        MODE_DATA  = 4'd1
    } eng_mode_e;
endpackage

// File: rtl/sbe_word_fifo.sv
// Circular word FIFO. A push when full is dropped; a pop when empty does
// nothing and the head reads as zero. Assumes DEPTH is a power of two.
module sbe_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int LVL_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] lvl_q;
    logic             do_push, do_pop;

    assign full    = (lvl_q == LVL_W'(DEPTH));
    assign empty   = (lvl_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rd_ptr];
    assign level   = lvl_q;

    // Storage write; contents are don't-care while the level says empty.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lvl_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end
endmodule

// File: rtl/sbe_rd_packer.sv
// Packs card bytes into words, little-endian. Emits a push on the last
// byte of a word or on the last byte of the transfer (upper bytes zero).
// Assumes the caller only asserts take when the FIFO can accept a word.
module sbe_rd_packer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         take,
    input  logic [7:0]   din,
    input  logic         last,
    output logic         push,
    output logic [W-1:0] word
);
    localparam int BYTES = W / 8;
    localparam int IDX_W = $clog2(BYTES);

    logic [W-1:0]     acc;
    logic [IDX_W-1:0] idx;
    logic [W-1:0]     merged;

    // Merge the incoming byte into its lane.
    always_comb begin
        merged = acc | (W'(din) << (8 * idx));
        push   = take && ((idx == IDX_W'(BYTES - 1)) || last);
        word   = merged;
    end

    // Accumulator and lane index.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
            idx <= '0;
        end else if (take) begin
            if (push) begin
                acc <= '0;
                idx <= '0;
            end else begin
                acc <= merged;
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbe_wr_unpacker.sv
// Sends FIFO words to the card one byte per handshake, LSB first. The
// first byte of a word comes straight from the FIFO head; the rest are
// held locally. Leftover bytes are dropped when the transfer ends.
module sbe_wr_unpacker #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         enable,
    input  logic         last,
    input  logic [W-1:0] head,
    input  logic         fifo_empty,
    input  logic         ready,
    output logic         valid,
    output logic [7:0]   data,
    output logic         pop,
    output logic         take
);
    localparam int BYTES = W / 8;
    localparam int CNT_W = $clog2(BYTES + 1);

    logic [W-1:0]     hold;
    logic [CNT_W-1:0] left;
    logic             have;

    // Byte selection and handshake.
    always_comb begin
        have  = (left != '0);
        valid = enable && (have || !fifo_empty);
        data  = have ? hold[7:0] : head[7:0];
        take  = valid && ready;
        pop   = take && !have;
    end

    // Remaining bytes of the word in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hold <= '0;
            left <= '0;
        end else if (take) begin
            if (last) begin
                hold <= '0;
                left <= '0;
            end else if (!have) begin
                hold <= head >> 8;
                left <= CNT_W'(BYTES - 1);
            end else begin
                hold <= hold >> 8;
                left <= left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbe_xfer_ctrl.sv
// Remaining byte counter, completion detection and sticky status.
// Assumes load never coincides with a byte step.
module sbe_xfer_ctrl
    import sbe_pkg::*;
#(
    parameter int BLKS_W = 9,
    parameter int BSZ_W  = 16,
    parameter int CNT_W  = BLKS_W + BSZ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_load,
    input  logic [BLKS_W-1:0] blk_cnt,
    input  logic [BSZ_W-1:0]  blk_size,
    input  logic              step,
    input  logic              evt,
    input  logic              cmd_busywait,
    input  logic              cmd_wr,
    input  logic              cfg_data_ie,
    input  logic              cfg_block_ie,
    input  logic              cfg_busy_ie,
    input  logic              sts_clr_we,
    input  logic [STS_W-1:0]  sts_clr_mask,
    output logic              rem_nz,
    output logic              rem_last,
    output logic [STS_W-1:0]  status,
    output logic              irq,
    output logic [3:0]        mode
);
    logic [CNT_W-1:0] rem_q, load_val;
    logic [STS_W-1:0] sts_q, sts_set, sts_clr;
    eng_mode_e        mode_q;
    logic             done_evt;

    // Completion detection and status set/clear vectors.
    always_comb begin
        load_val = CNT_W'(blk_cnt) * CNT_W'(blk_size);
        rem_nz   = (rem_q != '0);
        rem_last = (rem_q == CNT_W'(1));
        done_evt = (!cnt_load && step && rem_last)
                 || (!cnt_load && evt && !rem_nz)
                 || (cnt_load && (load_val == '0));
        sts_set               = '0;
        sts_set[ST_DONE]      = done_evt;
        sts_set[ST_DATA_IRQ]  = done_evt && cfg_data_ie;
        sts_set[ST_BLOCK_IRQ] = done_evt && cmd_wr && cfg_block_ie;
        sts_set[ST_BUSY_IRQ]  = done_evt && cmd_busywait && cfg_busy_ie;
        sts_clr               = sts_clr_we ? sts_clr_mask : '0;
    end

    // Remaining byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        rem_q <= '0;
        else if (cnt_load) rem_q <= load_val;
        else if (step)     rem_q <= rem_q - 1'b1;
    end

    // Sticky status and state field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q  <= '0;
            mode_q <= MODE_IDENT;
        end else begin
            sts_q <= ((sts_q & ~sts_clr) | sts_set) & STS_IMPL;
            if (done_evt) mode_q <= MODE_DATA;
        end
    end

    assign status = sts_q;
    assign irq    = |sts_q[ST_BUSY_IRQ:ST_DATA_IRQ];
    assign mode   = mode_q;
endmodule

// File: rtl/sbe_byte_engine.sv
// Top of the word FIFO to card byte stream engine. Routes the single FIFO
// to the packer (read direction) or unpacker (write direction).
// Assumes direction and command flags are stable while bytes move.
module sbe_byte_engine
    import sbe_pkg::*;
#(
    parameter int W      = 32,
    parameter int DEPTH  = 16,
    parameter int BLKS_W = 9,
    parameter int BSZ_W  = 16,
    parameter int LVL_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic              cmd_busywait,
    input  logic              cfg_data_ie,
    input  logic              cfg_block_ie,
    input  logic              cfg_busy_ie,
    input  logic              kick,
    input  logic              cnt_load,
    input  logic [BLKS_W-1:0] blk_cnt,
    input  logic [BSZ_W-1:0]  blk_size,
    input  logic              data_wr,
    input  logic [W-1:0]      data_wdata,
    input  logic              data_rd,
    output logic [W-1:0]      host_rdata,
    input  logic              card_rd_valid,
    input  logic [7:0]        card_rd_data,
    output logic              card_rd_ready,
    output logic              card_wr_valid,
    output logic [7:0]        card_wr_data,
    input  logic              card_wr_ready,
    input  logic              sts_clr_we,
    input  logic [STS_W-1:0]  sts_clr_mask,
    output logic [STS_W-1:0]  status,
    output logic              irq,
    output logic [3:0]        dbg_state,
    output logic [LVL_W-1:0]  dbg_fill
);
    localparam int CNT_W = BLKS_W + BSZ_W;

    logic         f_push, f_pop, f_full, f_empty;
    logic [W-1:0] f_wdata, f_rdata;
    logic         pk_push, rd_take, wr_pop, wr_take;
    logic [W-1:0] pk_word;
    logic         rem_nz, rem_last;

    // FIFO port steering by direction.
    always_comb begin
        rd_take       = card_rd_ready && card_rd_valid;
        card_rd_ready = cmd_rd && rem_nz && !f_full;
        f_push        = cmd_rd ? pk_push : data_wr;
        f_wdata       = cmd_rd ? pk_word : data_wdata;
        f_pop         = cmd_rd ? data_rd : wr_pop;
    end

    assign host_rdata = f_rdata;

    sbe_word_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f_push),
        .wdata (f_wdata),
        .pop   (f_pop),
        .rdata (f_rdata),
        .full  (f_full),
        .empty (f_empty),
        .level (dbg_fill)
    );

    sbe_rd_packer #(.W(W)) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_load),
        .take  (rd_take),
        .din   (card_rd_data),
        .last  (rem_last),
        .push  (pk_push),
        .word  (pk_word)
    );

    sbe_wr_unpacker #(.W(W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cnt_load),
        .enable     (!cmd_rd && rem_nz),
        .last       (rem_last),
        .head       (f_rdata),
        .fifo_empty (f_empty),
        .ready      (card_wr_ready),
        .valid      (card_wr_valid),
        .data       (card_wr_data),
        .pop        (wr_pop),
        .take       (wr_take)
    );

    sbe_xfer_ctrl #(.BLKS_W(BLKS_W), .BSZ_W(BSZ_W), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_load     (cnt_load),
        .blk_cnt      (blk_cnt),
        .blk_size     (blk_size),
        .step         (rd_take || wr_take),
        .evt          (kick || data_wr || data_rd),
        .cmd_busywait (cmd_busywait),
        .cmd_wr       (cmd_wr),
        .cfg_data_ie  (cfg_data_ie),
        .cfg_block_ie (cfg_block_ie),
        .cfg_busy_ie  (cfg_busy_ie),
        .sts_clr_we   (sts_clr_we),
        .sts_clr_mask (sts_clr_mask),
        .rem_nz       (rem_nz),
        .rem_last     (rem_last),
        .status       (status),
        .irq          (irq),
        .mode         (dbg_state)
    );
endmodule

// File: rtl/sbe_byte_engine_chk.sv
// Port-level properties of the byte stream engine, bound to the top.
module sbe_byte_engine_chk #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_rd,
    input logic             cmd_wr,
    input logic             cfg_block_ie,
    input logic             card_rd_ready,
    input logic             card_wr_valid,
    input logic [W-1:0]     host_rdata,
    input logic [LVL_W-1:0] dbg_fill,
    input logic [3:0]       dbg_state,
    input logic [10:0]      status
);
    p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dbg_fill) <= DEPTH);
    p_fill_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(dbg_fill) <= int'($past(dbg_fill)) + 1) &&
        (int'(dbg_fill) + 1 >= int'($past(dbg_fill))));
    p_empty_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_fill == '0) |-> (host_rdata == '0));
    p_rdy_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        card_rd_ready |-> (int'(dbg_fill) < DEPTH));
    p_wr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |-> !card_wr_valid);
    p_done_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> (dbg_state == 4'd1));
    p_block_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[9]) |-> $past(cmd_wr && cfg_block_ie));
endmodule

bind sbe_byte_engine sbe_byte_engine_chk #(.W(W), .DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (.*);

// File: tb/sbe_byte_engine_tb_top.sv
module sbe_byte_engine_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, cmd_rd, cmd_wr, cmd_busywait;
    logic        cfg_data_ie, cfg_block_ie, cfg_busy_ie, kick, cnt_load;
    logic [8:0]  blk_cnt;
    logic [15:0] blk_size;
    logic        data_wr, data_rd, card_rd_valid, card_wr_ready, sts_clr_we;
    logic [31:0] data_wdata, host_rdata;
    logic [7:0]  card_rd_data, card_wr_data;
    logic        card_rd_ready, card_wr_valid, irq;
    logic [10:0] sts_clr_mask, status;
    logic [3:0]  dbg_state;
    logic [4:0]  dbg_fill;

    sbe_byte_engine dut_i (.*);

    int checks = 0, errors = 0, cyc = 0;
    logic src_en = 1'b0, snk_en = 1'b0;

    // Behavioural reference state.
    logic [31:0] mq[$];
    int          m_rem, m_idx, m_wleft;
    logic [31:0] m_acc, m_wd;
    logic [10:0] m_sts;
    logic [3:0]  m_mode;
    logic [7:0]  src_byte;
    logic [7:0]  sent_q[$];

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_head();
        return (mq.size() != 0) ? mq[0] : 32'h0;
    endfunction

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mq.delete(); m_rem = 0; m_idx = 0; m_acc = 0; m_wd = 0; m_wleft = 0;
            m_sts = 0; m_mode = 0; src_byte = 8'h10;
        end else begin
            bit full, rtake, wtake, done, popped, prod0;
            logic [7:0] b;
            logic [31:0] pw;
            full   = (mq.size() == 16);
            rtake  = cmd_rd && card_rd_valid && m_rem != 0 && !full;
            wtake  = !cmd_rd && m_rem != 0 && (m_wleft != 0 || mq.size() != 0) && card_wr_ready;
            prod0  = (int'(blk_cnt) * int'(blk_size)) == 0;
            done   = (!cnt_load && (rtake || wtake) && m_rem == 1)
                   || (!cnt_load && (kick || data_wr || data_rd) && m_rem == 0)
                   || (cnt_load && prod0);
            popped = 0;
            if (cmd_rd && data_rd && mq.size() != 0) begin void'(mq.pop_front()); popped = 1; end
            if (!cmd_rd && data_wr && !full) mq.push_back(data_wdata);
            if (rtake) begin
                m_acc = m_acc | (32'(card_rd_data) << (8 * m_idx));
                if (m_idx == 3 || m_rem == 1) begin
                    mq.push_back(m_acc); m_acc = 0; m_idx = 0;
                end else m_idx++;
                m_rem--;
                src_byte = src_byte + 8'h1;
            end
            if (wtake) begin
                if (m_wleft == 0) begin
                    pw = mq.pop_front(); b = pw[7:0]; m_wd = pw >> 8; m_wleft = 3;
                end else begin
                    b = m_wd[7:0]; m_wd = m_wd >> 8; m_wleft--;
                end
                sent_q.push_back(b);
                m_rem--;
                if (m_rem == 0) begin m_wleft = 0; m_wd = 0; end
            end
            if (cnt_load) begin
                m_rem = int'(blk_cnt) * int'(blk_size);
                m_acc = 0; m_idx = 0; m_wd = 0; m_wleft = 0;
            end
            if (sts_clr_we) m_sts = m_sts & ~sts_clr_mask;
            if (done) begin
                m_sts[0] = 1'b1; m_mode = 4'd1;
                if (cfg_data_ie) m_sts[8] = 1'b1;
                if (cmd_wr && cfg_block_ie) m_sts[9] = 1'b1;
                if (cmd_busywait && cfg_busy_ie) m_sts[10] = 1'b1;
            end
        end
    end

    // Per-cycle comparison, 1 ns before the next rising edge.
    always @(negedge clk) begin
        #4;
        if (rst_n) begin
            bit exp_wv;
            exp_wv = !cmd_rd && m_rem != 0 && (m_wleft != 0 || mq.size() != 0);
            chk("R1", "dbg_fill", 64'(dbg_fill), 64'(mq.size()));
            chk("R2", "host_rdata", 64'(host_rdata), 64'(m_head()));
            chk("R4", "card_rd_ready", 64'(card_rd_ready),
                64'(cmd_rd && m_rem != 0 && mq.size() < 16));
            chk("R7", "card_wr_valid", 64'(card_wr_valid), 64'(exp_wv));
            if (exp_wv)
                chk("R7", "card_wr_data", 64'(card_wr_data),
                    64'((m_wleft != 0) ? m_wd[7:0] : m_head() & 32'hFF));
            chk("R12 status (R9 R10)", "status", 64'(status), 64'(m_sts));
            chk("R10", "irq", 64'(irq), 64'(|m_sts[10:8]));
            chk("R8", "dbg_state", 64'(dbg_state), 64'(m_mode));
        end
    end

    // Card source and sink with irregular handshakes.
    always @(negedge clk) begin
        card_rd_valid = src_en && (cyc % 3 != 1);
        card_rd_data  = src_byte;
        card_wr_ready = snk_en && (cyc % 4 != 2);
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(int c, int s);
        @(negedge clk); blk_cnt = 9'(c); blk_size = 16'(s); cnt_load = 1'b1;
        @(negedge clk); cnt_load = 1'b0;
    endtask

    task automatic pop_word(output logic [31:0] w);
        @(negedge clk); w = host_rdata; data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic push_word(logic [31:0] w);
        @(negedge clk); data_wdata = w; data_wr = 1'b1;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic clear_sts();
        @(negedge clk); sts_clr_we = 1'b1; sts_clr_mask = 11'h7FF;
        @(negedge clk); sts_clr_we = 1'b0;
    endtask

    task automatic pulse_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (status[0]) break;
        end
    endtask

    initial begin
        logic [31:0] w;
        rst_n = 0; cmd_rd = 1; cmd_wr = 0; cmd_busywait = 0;
        cfg_data_ie = 0; cfg_block_ie = 0; cfg_busy_ie = 0; kick = 0; cnt_load = 0;
        blk_cnt = 0; blk_size = 0; data_wr = 0; data_rd = 0; data_wdata = 0;
        sts_clr_we = 0; sts_clr_mask = 0;
        tick(3);
        rst_n = 1;
        tick(1);
        chk("R14", "reset fill", 64'(dbg_fill), 0);
        chk("R14", "reset status", 64'(status), 0);
        chk("R14", "reset state", 64'(dbg_state), 0);
        chk("R2", "empty head", 64'(host_rdata), 0);

        // Read transfer: 2 blocks of 9 bytes = 4 words plus a 2-byte tail.
        cfg_data_ie = 1; cfg_block_ie = 1; cfg_busy_ie = 1; cmd_busywait = 1;
        load(2, 9);
        src_en = 1;
        wait_done();
        src_en = 0;
        tick(2);
        chk("R3", "words after 18 bytes", 64'(dbg_fill), 5);
        chk("R8", "done bit", 64'(status[0]), 1);
        chk("R10", "busy bit, block bit", 64'(status[10:9]), 64'(2'b10));
        data_wr = 1; data_wdata = 32'hDEAD; tick(1); data_wr = 0; tick(1);
        chk("R13", "push ignored when reading", 64'(dbg_fill), 5);
        pop_word(w);
        chk("R5", "first packed word", 64'(w), 64'(32'h13121110));
        for (int i = 0; i < 3; i++) pop_word(w);
        pop_word(w);
        chk("R6", "partial tail word", 64'(w), 64'(32'h00002120));
        pop_word(w);
        chk("R2", "pop when empty", 64'(w), 0);

        // Overrun stall: 80 bytes with no host pops.
        clear_sts();
        chk("R12", "cleared status", 64'(status), 0);
        load(1, 80);
        src_en = 1;
        for (int i = 0; i < 400 && dbg_fill != 5'd16; i++) tick(1);
        tick(6);
        chk("R1", "fill at limit", 64'(dbg_fill), 16);
        chk("R4", "ready low when full", 64'(card_rd_ready), 0);
        pop_word(w);
        chk("R5", "word after stall", 64'(w), 64'(32'h25242322));
        for (int i = 0; i < 40 && !status[0]; i++) begin
            pop_word(w);
            tick(3);
        end
        src_en = 0;
        for (int i = 0; i < 20 && dbg_fill != 0; i++) pop_word(w);

        // Write transfer: 17 pushes into a 16-word FIFO, then send 10 bytes.
        cmd_rd = 0; cmd_wr = 1; cmd_busywait = 0;
        tick(1);
        for (int i = 0; i < 17; i++) push_word(32'hA0B0C0D0 + 32'(i));
        chk("R1", "push dropped when full", 64'(dbg_fill), 16);
        data_rd = 1; tick(1); data_rd = 0; tick(1);
        chk("R13", "pop ignored when writing", 64'(dbg_fill), 16);
        clear_sts();
        sent_q.delete();
        load(1, 10);
        snk_en = 1;
        wait_done();
        snk_en = 0;
        tick(2);
        chk("R7", "bytes sent", 64'(sent_q.size()), 10);
        chk("R7", "byte 0", 64'(sent_q[0]), 64'(8'hD0));
        chk("R7", "byte 3", 64'(sent_q[3]), 64'(8'hA0));
        chk("R7", "byte 4", 64'(sent_q[4]), 64'(8'hD1));
        chk("R7", "leftover bytes dropped", 64'(dbg_fill), 13);
        chk("R10", "block bit on write", 64'(status[10:8]), 64'(3'b011));

        // Completion re-evaluation with zero count, and gating.
        clear_sts();
        cfg_data_ie = 0;
        pulse_kick();
        tick(1);
        chk("R11", "kick at zero count", 64'(status[0]), 1);
        chk("R9", "data bit gated off", 64'(status[8]), 0);
        clear_sts();
        cfg_data_ie = 1; cmd_wr = 0;
        load(0, 5);
        tick(1);
        chk("R11", "zero product load", 64'(status[0]), 1);
        chk("R9", "data bit enabled", 64'(status[8]), 1);
        chk("R10", "irq follows bit 8", 64'(irq), 1);
        tick(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule